// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles a relative branch in one registered stage. Each cycle it takes a 32-bit branch word, the address of that word and the four arithmetic flags left by an earlier compare. It checks that the word really is a relative branch. It tests the 4-bit condition field against the flags, which covers equality, signed ordering, unsigned ordering, sign and overflow tests, and the always and never forms. It also forms the destination by sign-extending the 24-bit word count and scaling it to bytes.

The result appears one clock after the inputs. It has three parts: a taken strobe, the computed destination, and the address to fetch next, which is either the destination or the sequential address four bytes on. A fetch unit uses the block to steer its program counter. Because the offset is relative to the branch's own address, the code it runs stays position independent. The flag input packs N in bit 3, Z in bit 2, C in bit 1 and V in bit 0.

Top module: `branch_resolver`

## Requirements
- R1: While rst_ni is low, taken_o, target_o and next_pc_o are all zero.
- R2: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: A word whose bits 27:24 are not 1010 is not a branch: taken_o is low and next_pc_o is pc+4, whatever the condition field and flags.
- R4: target_o equals pc plus four times the signed value of bits 23:0, modulo 2^32. A negative offset gives a lower address. The target is formed for every word.
- R5: Condition 0000 is taken when Z=1, and 0001 is taken when Z=0.
- R6: Unsigned tests: 0010 is taken when C=1, 0011 when C=0, 1000 when C=1 and Z=0, and 1001 when C=0 or Z=1.
- R7: Signed tests: 1010 is taken when N=V, 1011 when N≠V, 1100 when Z=0 and N=V, and 1101 when Z=1 or N≠V.
- R8: Single-flag tests: 0100 is taken when N=1, 0101 when N=0, 0110 when V=1 and 0111 when V=0.
- R9: For a valid branch word, condition 1110 is always taken and 1111 is never taken.
- R10: next_pc_o equals target_o when taken_o is high and pc+4 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Branch word: condition 31:28, tag 27:24, word offset 23:0 |
| pc_i | input | 32 | Byte address of the branch word |
| flags_i | input | 4 | Flags {N, Z, C, V} |
| taken_o | output | 1 | Branch taken |
| target_o | output | 32 | Computed destination address |
| next_pc_o | output | 32 | Address to fetch next |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 24-bit word offset and a two-bit byte shift. With these values the bench can sweep all sixteen condition codes against all sixteen flag combinations. It can also reach the sign bit of the offset with the most negative and most positive counts, and it makes the 32-bit sum wrap past zero and past the top of the address space. Wrong tags, a worked forward branch of eight words, and random words are checked against a behavioural model every clock.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int unsigned COND_W = 4;
  localparam int unsigned TAG_W  = 4;
  localparam logic [TAG_W-1:0] BRANCH_TAG = 4'b1010;

  typedef enum logic [COND_W-1:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/br_field_split.sv
module br_field_split
  import br_pkg::*;
#(
  parameter int unsigned OFS_W  = 24,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned INSN_W = COND_W + TAG_W + OFS_W
) (
  input  logic [INSN_W-1:0] insn_i,
  output cond_e             cond_o,
  output logic              is_branch_o,
  output logic [ADDR_W-1:0] ofs_ext_o
);
  localparam int unsigned TAG_LO  = OFS_W;
  localparam int unsigned COND_LO = OFS_W + TAG_W;

  logic [OFS_W-1:0] ofs_raw;

  assign cond_o      = cond_e'(insn_i[COND_LO +: COND_W]);
  assign is_branch_o = (insn_i[TAG_LO +: TAG_W] == BRANCH_TAG);
  assign ofs_raw     = insn_i[OFS_W-1:0];

  generate
    if (ADDR_W > OFS_W) begin : g_ext
      assign ofs_ext_o = {{(ADDR_W-OFS_W){ofs_raw[OFS_W-1]}}, ofs_raw};
    end else begin : g_trunc
      assign ofs_ext_o = ofs_raw[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   pass_o
);
  localparam int unsigned N_COND = 1 << COND_W;

  logic [N_COND/2-1:0] base;
  logic [N_COND-1:0]   pass_vec;

  // even codes hold the base test, odd codes its complement
  always_comb begin
    base[0] = flags_i.z;
    base[1] = flags_i.c;
    base[2] = flags_i.n;
    base[3] = flags_i.v;
    base[4] = flags_i.c & ~flags_i.z;
    base[5] = (flags_i.n == flags_i.v);
    base[6] = ~flags_i.z & (flags_i.n == flags_i.v);
    base[7] = 1'b1;
  end

  generate
    for (genvar i = 0; i < N_COND/2; i++) begin : g_pair
      assign pass_vec[2*i]   = base[i];
      assign pass_vec[2*i+1] = (i == N_COND/2-1) ? 1'b0 : ~base[i];
    end
  endgenerate

  assign pass_o = pass_vec[cond_i];
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] ofs_ext_i,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] seq_pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHIFT;

  assign target_o = pc_i + (ofs_ext_i << WORD_SHIFT);
  assign seq_pc_o = pc_i + STEP;
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OFS_W      = 24,
  parameter int unsigned WORD_SHIFT = 2,
  localparam int unsigned INSN_W    = COND_W + TAG_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [3:0]        flags_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  cond_e             cond;
  logic              is_branch;
  logic [ADDR_W-1:0] ofs_ext;
  logic              cond_pass;
  logic [ADDR_W-1:0] target_d;
  logic [ADDR_W-1:0] seq_pc;
  logic              taken_d;

  br_field_split #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_split (
    .insn_i     (insn_i),
    .cond_o     (cond),
    .is_branch_o(is_branch),
    .ofs_ext_o  (ofs_ext)
  );

  br_cond_eval u_cond (
    .cond_i (cond),
    .flags_i(flags_t'(flags_i)),
    .pass_o (cond_pass)
  );

  br_target_calc #(.ADDR_W(ADDR_W), .WORD_SHIFT(WORD_SHIFT)) u_tgt (
    .pc_i     (pc_i),
    .ofs_ext_i(ofs_ext),
    .target_o (target_d),
    .seq_pc_o (seq_pc)
  );

  assign taken_d = is_branch & cond_pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o   <= 1'b0;
      target_o  <= '0;
      next_pc_o <= '0;
    end else begin
      taken_o   <= taken_d;
      target_o  <= target_d;
      next_pc_o <= taken_d ? target_d : seq_pc;
    end
  end

  // one cycle of history exists before $past is trusted
  logic primed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  localparam logic [ADDR_W-1:0] STEP_CHK = ADDR_W'(1) << WORD_SHIFT;

  // R3
  not_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(insn_i[OFS_W +: TAG_W] != BRANCH_TAG)
      |-> !taken_o && next_pc_o == $past(pc_i) + STEP_CHK);

  // R9
  never_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(insn_i[INSN_W-1 -: COND_W] == 4'hF) |-> !taken_o);

  // R9
  always_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(insn_i[INSN_W-1 -: COND_W] == 4'hE
                      && insn_i[OFS_W +: TAG_W] == BRANCH_TAG) |-> taken_o);

  // R5
  eq_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(insn_i[INSN_W-1 -: COND_W] == 4'h0
                      && insn_i[OFS_W +: TAG_W] == BRANCH_TAG)
      |-> taken_o == $past(flags_i[2]));

  // R4
  target_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> target_o[WORD_SHIFT-1:0] == $past(pc_i[WORD_SHIFT-1:0]));

  // R10
  next_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> next_pc_o == (taken_o ? target_o : $past(pc_i) + STEP_CHK));
endmodule

// File: tb/branch_resolver_tb_top.sv
`timescale 1ns/1ps
module branch_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] pc = '0;
  logic [3:0]  flags = '0;
  logic        taken;
  logic [31:0] target;
  logic [31:0] next_pc;

  int n_vec = 0;
  int n_bad = 0;

  typedef struct {
    logic        tk;
    logic [31:0] tg;
    logic [31:0] np;
    string       req;
  } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;

  branch_resolver dut_i (
    .clk_i(clk), .rst_ni(rst_n), .insn_i(insn), .pc_i(pc), .flags_i(flags),
    .taken_o(taken), .target_o(target), .next_pc_o(next_pc)
  );

  function automatic bit cond_ok(int code, logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (code)
      0: return z;            1: return !z;
      2: return c;            3: return !c;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return c && !z;      9: return !c || z;
      10: return n == v;      11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      14: return 1;           default: return 0;
    endcase
  endfunction

  function automatic exp_t model(logic [31:0] w, logic [31:0] p, logic [3:0] f, string r);
    exp_t e;
    longint ofs = longint'(w[23:0]);
    if (ofs >= 64'd8388608) ofs -= 64'd16777216;
    e.tg = 32'(longint'(p) + ofs * 4);
    e.tk = (w[27:24] == 4'b1010) && cond_ok(int'(w[31:28]), f);
    e.np = e.tk ? e.tg : p + 32'd4;
    e.req = r;
    return e;
  endfunction

  task automatic check(string req, logic tk, logic [31:0] tg, logic [31:0] np);
    n_vec++;
    if (taken !== tk || target !== tg || next_pc !== np) begin
      n_bad++;
      $display("FAIL %s: taken/target/next = %0b/%h/%h expected %0b/%h/%h",
               req, taken, target, next_pc, tk, tg, np);
    end
  endtask

  // drive after #1 past the edge, check outputs of the previous vector
  task automatic apply(logic [31:0] w, logic [31:0] p, logic [3:0] f, string r);
    exp_t e;
    insn = w; pc = p; flags = f;
    expq.push_back(model(w, p, f, r));
    @(posedge clk); #1;
    e = expq.pop_front();
    check({"R2 ", e.req}, e.tk, e.tg, e.np);
  endtask

  function automatic logic [31:0] mk(int code, logic [3:0] tag, logic [23:0] ofs);
    return {4'(code), tag, ofs};
  endfunction

  initial begin
    #10000000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    insn = 32'hEA00_0005; pc = 32'h0000_4000; flags = 4'hF;
    @(posedge clk); #1;
    check("R1 reset", 1'b0, 32'h0, 32'h0);
    @(posedge clk); #1;
    check("R1 reset held", 1'b0, 32'h0, 32'h0);
    rst_n = 1'b1;

    // worked forward branch: pc 0x1000, offset 8
    apply(mk(14, 4'hA, 24'd8), 32'h1000, 4'h0, "R4 R9 fwd");
    if (target !== 32'h1020) begin
      n_bad++; $display("FAIL R4: target %h expected 00001020", target);
    end
    n_vec++;

    // full condition x flag grid
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        string r;
        if (c < 2) r = "R5";
        else if (c < 4 || c == 8 || c == 9) r = "R6";
        else if (c < 8) r = "R8";
        else if (c < 14) r = "R7";
        else r = "R9";
        apply(mk(c, 4'hA, 24'(c * 16 + f)), 32'h2000_0000 + 32'(f * 4), 4'(f), r);
      end
    end

    // wrong tags never branch
    for (int t = 0; t < 16; t++) begin
      if (t != 10) apply(mk(14, 4'(t), 24'h000100), 32'h8000_0000, 4'h4, "R3");
    end
    apply(mk(0, 4'hB, 24'h7FFFFF), 32'h10, 4'h4, "R3 eq tag off");

    // offset extremes and wrap
    apply(mk(14, 4'hA, 24'h800000), 32'h0200_0000, 4'h0, "R4 most negative");
    apply(mk(14, 4'hA, 24'h7FFFFF), 32'h0000_0000, 4'h0, "R4 most positive");
    apply(mk(14, 4'hA, 24'hFFFFFF), 32'h0000_0000, 4'h0, "R4 wrap below zero");
    apply(mk(14, 4'hA, 24'h000004), 32'hFFFF_FFF8, 4'h0, "R4 wrap over top");
    apply(mk(15, 4'hA, 24'hFFFFF0), 32'h0000_0400, 4'hF, "R4 R10 never");
    apply(mk(11, 4'hA, 24'hFFFFFE), 32'h0000_1008, 4'h8, "R7 R10 backward loop");

    // random words, mostly valid tags
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w = $urandom;
      if (i % 4 != 0) w[27:24] = 4'hA;
      apply(w, $urandom, 4'($urandom), "R10 random");
    end

    // reset mid-run clears outputs
    #1 rst_n = 1'b0;
    #1 check("R1 async reset", 1'b0, 32'h0, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule